// File: doc/BRIEF.md
# Multi-channel periodic timer

This block holds a bank of independent 32-bit down-counters that all run on one module clock. Software programs a reload value per channel and starts the channel. The channel then counts down one step per clock. When it passes zero it reloads, raises a sticky flag and drives a one-cycle trigger pulse. The flag, gated by a per-channel interrupt-enable bit, becomes the channel's interrupt request. A new reload value written while a channel runs is held until the current period has run out. A debug-freeze input stops every counter in place. A global disable bit, set at reset, keeps the whole bank idle until software clears it.

The register port is a plain single-cycle port rather than a stream. A write is taken on the clock edge where `wr_en` is high, so it never applies back-pressure. Reads are combinational from `addr`. Words are indexed by `addr[AW-1:2]`. Index 0 holds the global control word, whose bit 0 is the disable bit. Index c+1 holds channel c, and `addr[1:0]` selects the register within the channel:

| Offset | Register |
|---|---|
| 0 | reload value |
| 1 | live count, read-only |
| 2 | control: bit 0 run, bit 1 interrupt enable |
| 3 | flag, bit 0 |

Top module: `pit_bank`

## Requirements
- R1: A running channel times out once every (reload value + 1) clock cycles. The first timeout comes (reload + 1) edges after the edge that started the channel.
- R2: A write to control that turns run from 0 to 1 loads the counter from the reload register. Clearing run stops the channel, and the count holds its value. The live count is readable at offset 1.
- R3: A reload value written while the channel runs leaves the current countdown unchanged. The counter takes the new value only at the next timeout.
- R4: While `dbg_freeze` is high, no counter changes and no timeout occurs. When it drops, counting resumes from the held values.
- R5: Each timeout sets the channel's flag and pulses `trig` for exactly one cycle, whether or not the interrupt is enabled.
- R6: Writing a 1 to flag bit 0 clears the flag, and writing a 0 has no effect. If a clear and a timeout fall on the same edge, the flag stays set.
- R7: `irq[c]` is high exactly when the channel's flag and interrupt-enable bit are both 1. Enabling the interrupt while the flag is already set raises `irq` at once.
- R8: The global disable bit (index 0, bit 0) resets to 1. While it is 1, no channel counts or times out.
- R9: Registers decode as described above. Unmapped addresses read 0, and writes to the live-count register are ignored.
- R10: After reset all reload values, counts, control bits and flags are 0, and `irq` and `trig` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_freeze | input | 1 | Holds every counter while high |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register word address |
| wdata | input | CW | Write data |
| rdata | output | CW | Combinational read data for `addr` |
| irq | output | NCH | Per-channel interrupt request |
| trig | output | NCH | Per-channel one-cycle timeout pulse |

## Verification
Directed sequences measure the first period and the steady period separately. They distinguish a reload taken on the start edge from one taken a cycle late, and a late-reload write from one that cuts the period short. One sequence times a flag clear to land on a timeout edge. Freeze and disable are held long enough to tell a frozen counter from a slow one. A seeded random phase then mixes short reload values, start/stop, enable toggling, clears, freezes and disable writes across all channels. Each cycle's `irq`, `trig` and a random read are compared against a cycle model built from the requirements, which exposes ordering mistakes between writes and counting.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam logic [1:0] REG_LOAD = 2'd0;
  localparam logic [1:0] REG_CNT  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_FLAG = 2'd3;

  localparam int RUN_BIT = 0;
  localparam int IE_BIT  = 1;
  localparam int CLR_BIT = 0;
  localparam int OFF_BIT = 0;

  typedef struct packed {
    logic ie;
    logic run;
  } pit_ctrl_t;
endpackage

// File: rtl/pit_chan.sv
module pit_chan
  import pit_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic          wr_flag,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] load_o,
  output logic [CW-1:0] cnt_o,
  output logic          run_o,
  output logic          ie_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          trig_o
);
  logic [CW-1:0] load_q;
  logic [CW-1:0] cnt_q;
  pit_ctrl_t     ctrl_q;
  logic          flag_q;
  logic          trig_q;
  logic          arm;
  logic          step;
  logic          expire;

  // start edge: run goes 0 -> 1 through a control write
  assign arm    = wr_ctrl && wdata[RUN_BIT] && !ctrl_q.run;
  assign step   = cnt_en && ctrl_q.run;
  assign expire = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) begin
        ctrl_q.run <= wdata[RUN_BIT];
        ctrl_q.ie  <= wdata[IE_BIT];
      end
      if (arm) begin
        cnt_q <= load_q;
      end else if (step) begin
        cnt_q <= expire ? load_q : cnt_q - 1'b1;
      end
      trig_q <= expire;
      if (expire) begin
        flag_q <= 1'b1;
      end else if (wr_flag && wdata[CLR_BIT]) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign run_o  = ctrl_q.run;
  assign ie_o   = ctrl_q.ie;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ctrl_q.ie;
  assign trig_o = trig_q;
endmodule

// File: rtl/pit_regif.sv
module pit_regif
  import pit_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic                    off_q,
  input  logic [NCH-1:0][CW-1:0]  load_v,
  input  logic [NCH-1:0][CW-1:0]  cnt_v,
  input  logic [NCH-1:0]          run_v,
  input  logic [NCH-1:0]          ie_v,
  input  logic [NCH-1:0]          flag_v,
  output logic [NCH-1:0]          wr_load_v,
  output logic [NCH-1:0]          wr_ctrl_v,
  output logic [NCH-1:0]          wr_flag_v,
  output logic                    wr_glob,
  output logic [CW-1:0]           rdata
);
  localparam int IDXW = AW - 2;

  logic [IDXW-1:0] idx;
  logic [1:0]      sub;
  logic            glob_sel;
  logic [NCH-1:0]  ch_sel;

  assign idx      = addr[AW-1:2];
  assign sub      = addr[1:0];
  assign glob_sel = (idx == '0) && (sub == REG_LOAD);
  assign wr_glob  = wr_en && glob_sel;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign ch_sel[c]    = (idx == IDXW'(c + 1));
    assign wr_load_v[c] = wr_en && ch_sel[c] && (sub == REG_LOAD);
    assign wr_ctrl_v[c] = wr_en && ch_sel[c] && (sub == REG_CTRL);
    assign wr_flag_v[c] = wr_en && ch_sel[c] && (sub == REG_FLAG);
  end

  always_comb begin
    rdata = '0;
    if (glob_sel) rdata[OFF_BIT] = off_q;
    for (int c = 0; c < NCH; c++) begin
      if (ch_sel[c]) begin
        case (sub)
          REG_LOAD: rdata = load_v[c];
          REG_CNT:  rdata = cnt_v[c];
          REG_CTRL: begin
            rdata[RUN_BIT] = run_v[c];
            rdata[IE_BIT]  = ie_v[c];
          end
          default:  rdata[CLR_BIT] = flag_v[c];
        endcase
      end
    end
  end
endmodule

// File: rtl/pit_bank.sv
module pit_bank
  import pit_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dbg_freeze,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] trig
);
  logic                   off_q;
  logic                   cnt_en;
  logic                   wr_glob;
  logic [NCH-1:0]         wr_load_v;
  logic [NCH-1:0]         wr_ctrl_v;
  logic [NCH-1:0]         wr_flag_v;
  logic [NCH-1:0][CW-1:0] load_v;
  logic [NCH-1:0][CW-1:0] cnt_v;
  logic [NCH-1:0]         run_v;
  logic [NCH-1:0]         ie_v;
  logic [NCH-1:0]         flag_v;

  always_ff @(posedge clk) begin
    if (!rst_n)       off_q <= 1'b1;
    else if (wr_glob) off_q <= wdata[OFF_BIT];
  end

  assign cnt_en = !off_q && !dbg_freeze;

  pit_regif #(.NCH(NCH), .CW(CW), .AW(AW)) u_regif (
    .wr_en     (wr_en),
    .addr      (addr),
    .off_q     (off_q),
    .load_v    (load_v),
    .cnt_v     (cnt_v),
    .run_v     (run_v),
    .ie_v      (ie_v),
    .flag_v    (flag_v),
    .wr_load_v (wr_load_v),
    .wr_ctrl_v (wr_ctrl_v),
    .wr_flag_v (wr_flag_v),
    .wr_glob   (wr_glob),
    .rdata     (rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pit_chan #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .wr_load (wr_load_v[c]),
      .wr_ctrl (wr_ctrl_v[c]),
      .wr_flag (wr_flag_v[c]),
      .wdata   (wdata),
      .load_o  (load_v[c]),
      .cnt_o   (cnt_v[c]),
      .run_o   (run_v[c]),
      .ie_o    (ie_v[c]),
      .flag_o  (flag_v[c]),
      .irq_o   (irq[c]),
      .trig_o  (trig[c])
    );
  end
endmodule

// File: rtl/pit_bank_chk.sv
module pit_bank_chk #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dbg_freeze,
  input logic                   wr_en,
  input logic [AW-1:0]          addr,
  input logic                   wdata_lsb,
  input logic                   off_q,
  input logic [NCH-1:0][CW-1:0] cnt_v,
  input logic [NCH-1:0]         flag_v,
  input logic [NCH-1:0]         ie_v,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0]         trig
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic clr_hit;
    assign clr_hit = wr_en && wdata_lsb && (addr == AW'(((c + 1) * 4) + 3));

    // R5: a trigger pulse always accompanies a set flag
    a_r5_trig_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      trig[c] |-> flag_v[c]);

    // R6: only a write of 1 to the flag register clears it
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_v[c] && !clr_hit) |=> flag_v[c]);

    // R7: masked channel never interrupts
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_v[c] |-> !irq[c]);

    // R7: enabled and flagged channel interrupts
    a_r7_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_v[c] && ie_v[c]) |-> irq[c]);
  end

  // R4: freeze holds every count
  a_r4_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_freeze && !wr_en) |=> $stable(cnt_v));

  // R8: disabled bank neither counts nor times out
  a_r8_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !wr_en) |=> ($stable(cnt_v) && (trig == '0)));
endmodule

bind pit_bank pit_bank_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dbg_freeze (dbg_freeze),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata_lsb  (wdata[0]),
  .off_q      (off_q),
  .cnt_v      (cnt_v),
  .flag_v     (flag_v),
  .ie_v       (ie_v),
  .irq        (irq),
  .trig       (trig)
);

// File: tb/sim_pit_bank.sv
module sim_pit_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 32;
  localparam int AW  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           dbg_freeze = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [CW-1:0]  wdata = '0;
  logic [CW-1:0]  rdata;
  logic [NCH-1:0] irq;
  logic [NCH-1:0] trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // cycle model built from the requirements
  logic [CW-1:0] m_load [NCH];
  logic [CW-1:0] m_cnt  [NCH];
  bit            m_run  [NCH];
  bit            m_ie   [NCH];
  bit            m_flag [NCH];
  bit            m_trig [NCH];
  bit            m_off;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pit_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .dbg_freeze(dbg_freeze), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .trig(trig)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_trig();
    logic [31:0] v = '0;
    for (int c = 0; c < NCH; c++) v[c] = m_trig[c];
    return v;
  endfunction

  function automatic logic [31:0] exp_irq();
    logic [31:0] v = '0;
    for (int c = 0; c < NCH; c++) v[c] = m_flag[c] & m_ie[c];
    return v;
  endfunction

  function automatic logic [31:0] mread(logic [AW-1:0] a);
    int idx = int'(a[AW-1:2]);
    logic [31:0] v = '0;
    if (idx == 0) begin
      if (a[1:0] == 2'd0) v[0] = m_off;
    end else if (idx <= NCH) begin
      case (a[1:0])
        2'd0: v = m_load[idx-1];
        2'd1: v = m_cnt[idx-1];
        2'd2: v = {30'b0, m_ie[idx-1], m_run[idx-1]};
        default: v[0] = m_flag[idx-1];
      endcase
    end
    return v;
  endfunction

  task automatic model_step(bit we, logic [AW-1:0] a, logic [31:0] d, bit frz);
    int idx = int'(a[AW-1:2]);
    bit act = !m_off && !frz;
    for (int c = 0; c < NCH; c++) begin
      bit sel = we && (idx == c + 1);
      bit to = 1'b0;
      if (sel && a[1:0] == 2'd2 && d[0] && !m_run[c]) begin
        m_cnt[c] = m_load[c];
      end else if (act && m_run[c]) begin
        if (m_cnt[c] == 0) begin
          m_cnt[c] = m_load[c];
          to = 1'b1;
        end else begin
          m_cnt[c] = m_cnt[c] - 1;
        end
      end
      if (to) m_flag[c] = 1'b1;
      else if (sel && a[1:0] == 2'd3 && d[0]) m_flag[c] = 1'b0;
      m_trig[c] = to;
      if (sel && a[1:0] == 2'd0) m_load[c] = d;
      if (sel && a[1:0] == 2'd2) begin
        m_run[c] = d[0];
        m_ie[c]  = d[1];
      end
    end
    if (we && a == '0) m_off = d[0];
  endtask

  // one clock: drive, advance the model, sample at the following falling edge
  task automatic tick(bit we, logic [AW-1:0] a, logic [31:0] d, bit frz);
    wr_en = we;
    addr = a;
    wdata = d;
    dbg_freeze = frz;
    model_step(we, a, d, frz);
    @(negedge clk);
    wr_en = 1'b0;
    dbg_freeze = 1'b0;
    chk("R1 R5 trig", 32'(trig), exp_trig());
    chk("R7 irq", 32'(irq), exp_irq());
  endtask

  task automatic idle();
    tick(1'b0, '0, '0, 1'b0);
  endtask

  task automatic rd(string tag, logic [AW-1:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic peek(logic [AW-1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_trig(int ch, output int n);
    n = 0;
    do begin
      idle();
      n++;
    end while (!trig[ch] && n < 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] v1;
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin
      m_load[c] = '0; m_cnt[c] = '0; m_run[c] = 0;
      m_ie[c] = 0; m_flag[c] = 0; m_trig[c] = 0;
    end
    m_off = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 trig low", 32'(trig), 0);
    chk("R10 irq low", 32'(irq), 0);
    rd("R8 R10 disable set at reset", 8'h00, 1);
    rd("R10 reload zero", 8'h04, 0);
    rd("R10 count zero", 8'h05, 0);

    // R9 register map
    tick(1, 8'h08, 32'h0003_E7FF, 0);
    rd("R9 reload ch1 readback", 8'h08, 32'h0003_E7FF);
    tick(1, 8'h09, 32'h1234_5678, 0);
    rd("R9 count write ignored", 8'h09, 0);
    rd("R9 unmapped reads zero", 8'h40, 0);

    // R8 enable the bank, R2 start loads counter
    tick(1, 8'h00, 0, 0);
    rd("R8 disable cleared", 8'h00, 0);
    tick(1, 8'h04, 3, 0);
    tick(1, 8'h06, 1, 0);
    rd("R2 start loads reload", 8'h05, 3);

    // R1 periods
    wait_trig(0, n);
    chk("R1 first period", n, 4);
    wait_trig(0, n);
    chk("R1 steady period", n, 4);
    rd("R5 flag set on timeout", 8'h07, 1);
    chk("R5 R7 masked irq", 32'(irq[0]), 0);

    // R7 enable with flag pending; also stops the channel
    tick(1, 8'h06, 2, 0);
    chk("R7 irq at once", 32'(irq[0]), 1);
    peek(8'h05, v1);
    repeat (3) idle();
    rd("R2 stopped count holds", 8'h05, v1);

    // R6 write-one-to-clear
    tick(1, 8'h07, 0, 0);
    rd("R6 write 0 no effect", 8'h07, 1);
    tick(1, 8'h07, 1, 0);
    rd("R6 write 1 clears", 8'h07, 0);
    chk("R7 irq drops with flag", 32'(irq[0]), 0);

    // R3 reload written mid-period
    tick(1, 8'h06, 1, 0);
    idle();
    tick(1, 8'h04, 9, 0);
    wait_trig(0, n);
    chk("R3 current period kept", n, 2);
    wait_trig(0, n);
    chk("R3 new reload next period", n, 10);

    // R6 clear on the timeout edge loses
    repeat (9) idle();
    tick(1, 8'h07, 1, 0);
    chk("R6 timeout on clear edge", 32'(trig[0]), 1);
    rd("R6 flag survives clear", 8'h07, 1);

    // R4 freeze
    peek(8'h05, v1);
    repeat (10) tick(0, 8'h00, 0, 1);
    rd("R4 freeze holds", 8'h05, v1);
    idle();
    rd("R4 resumes after freeze", 8'h05, v1 - 1);

    // R8 bank disable
    tick(1, 8'h00, 1, 0);
    peek(8'h05, v1);
    repeat (6) idle();
    rd("R8 disabled holds", 8'h05, v1);
    tick(1, 8'h00, 0, 0);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      bit frz = ($urandom_range(0, 9) == 0);
      if (r < 60) begin
        tick(0, 8'h00, 0, frz);
      end else if (r < 63) begin
        tick(1, 8'h00, 32'($urandom_range(0, 4) == 0), frz);
      end else begin
        int ch = $urandom_range(0, NCH - 1);
        int rg = $urandom_range(0, 3);
        logic [31:0] d;
        case (rg)
          0: d = $urandom_range(0, 12);
          1: d = $urandom;
          2: d = $urandom_range(0, 3);
          default: d = $urandom_range(0, 1);
        endcase
        tick(1, AW'((ch + 1) * 4 + rg), d, frz);
      end
      begin
        logic [AW-1:0] ra = ($urandom_range(0, 9) == 0) ? AW'($urandom)
                                                       : AW'($urandom_range(0, 19));
        rd("R1 R2 R3 R9 random readback", ra, mread(ra));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule